// File: doc/BRIEF.md
# Lockstep Result Comparator with Safe-Off Latch

This block sits behind two processor cores running in lockstep on identical inputs. The primary core's result bus, together with its valid strobe, is the only one passed on to the rest of the system. The shadow core's result bus is used only for comparison against the primary bus and never reaches an output.

Each cycle the block checks the two buses. If they disagree, it latches a fault and switches to a safe-off state. The fault flag stays set until reset or until software writes a clear. The block sends one interrupt pulse to the interrupt controller on the first disagreement. While safe-off is held, the forwarded result is forced to an inactive all-zero value, so a backup mechanism can take control without interference. The result of the cycle that disagrees is also blocked and never reaches the outputs.

Top module: `lockstep_guard`

## Requirements
- R1: While no fault is latched and the buses agree in the current cycle, `out_valid` equals `pri_valid` and `out_data` equals `pri_data` in the same cycle. The shadow bus never appears on the outputs.
- R2: When both strobes are high and the data words differ in any bit, the cycle counts as a mismatch. When both strobes are low, the data words are not compared and no mismatch arises.
- R3: When exactly one of `pri_valid` and `shd_valid` is high, the cycle counts as a mismatch, whatever the data words hold.
- R4: A mismatch sampled at a clock edge sets `fault` and `safe_off` high right after that edge.
- R5: `irq` is high for exactly the one cycle that follows the edge at which the first mismatch is sampled. Further mismatches while the fault is latched raise no new pulse.
- R6: `fault` and `safe_off` stay high until reset or clear. `clear_fault` sampled high at an edge with no mismatch drops both after that edge. If a mismatch is sampled at the same edge as the clear, the mismatch wins and both stay high.
- R7: While `safe_off` is high, or while the current cycle is a mismatch, `out_valid` is 0 and `out_data` is all zeros.
- R8: Reset is synchronous and active high. After a reset edge, `fault`, `safe_off` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_valid | input | 1 | Primary core result strobe |
| pri_data | input | DATA_W | Primary core result word |
| shd_valid | input | 1 | Shadow core result strobe |
| shd_data | input | DATA_W | Shadow core result word |
| clear_fault | input | 1 | Software clear of the latched fault |
| out_valid | output | 1 | Forwarded strobe, held low in safe-off |
| out_data | output | DATA_W | Forwarded result, forced to zero in safe-off |
| fault | output | 1 | Sticky fault flag |
| irq | output | 1 | One-cycle interrupt request on first fault |
| safe_off | output | 1 | Safe-off state indicator |

## Verification
The bench uses a 4-bit result width. It sweeps every pair of primary and shadow words with both strobes high, which separates equal words (passed through) from words that differ in any single or multiple bit (blocked and latched). It then drives single-strobe cycles with equal data, to show that strobe disagreement alone trips the latch, and both-low cycles with unequal data, to show that the data words are not compared. Back-to-back mismatches, a clear in the same cycle as a mismatch, and matching traffic during safe-off check the one-pulse interrupt, the clear priority and the output forcing.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;

    typedef enum logic [0:0] {
        GS_RUN  = 1'b0,
        GS_SAFE = 1'b1
    } guard_state_e;

    typedef struct packed {
        logic fault;
        logic safe_off;
        logic irq;
    } guard_status_t;

    // Mismatch has priority over clear; clear only leaves SAFE on a clean cycle.
    function automatic guard_state_e guard_next(
        input guard_state_e cur,
        input logic         miss,
        input logic         clr
    );
        guard_state_e nxt;
        nxt = cur;
        if (miss)
            nxt = GS_SAFE;
        else if (clr)
            nxt = GS_RUN;
        return nxt;
    endfunction

endpackage

// File: rtl/ls_compare.sv
module ls_compare #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_valid,
    input  logic [DATA_W-1:0] a_data,
    input  logic              b_valid,
    input  logic [DATA_W-1:0] b_data,
    output logic              miss
);
    logic [DATA_W-1:0] bit_diff;
    logic              data_diff;
    logic              strobe_diff;
    logic              both_valid;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_bit
            assign bit_diff[gi] = a_data[gi] ^ b_data[gi];
        end
    endgenerate

    always_comb begin
        data_diff   = |bit_diff;
        strobe_diff = a_valid ^ b_valid;
        both_valid  = a_valid & b_valid;
        miss        = strobe_diff | (both_valid & data_diff);
    end

    // R2: identical valid words never count as a mismatch
    p_equal_no_miss_r2: assert property (@(posedge clk) disable iff (rst)
        (a_valid && b_valid && a_data == b_data) |-> !miss);
    // R2: idle on both sides never compares
    p_idle_no_miss_r2: assert property (@(posedge clk) disable iff (rst)
        (!a_valid && !b_valid) |-> !miss);
    // R3: strobe disagreement is a mismatch
    p_strobe_miss_r3: assert property (@(posedge clk) disable iff (rst)
        (a_valid != b_valid) |-> miss);
endmodule

// File: rtl/ls_fault_latch.sv
module ls_fault_latch
    import lockstep_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          miss,
    input  logic          clr,
    output guard_status_t status
);
    guard_state_e state_q;
    logic         irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GS_RUN;
            irq_q   <= 1'b0;
        end else begin
            state_q <= guard_next(state_q, miss, clr);
            irq_q   <= miss && (state_q == GS_RUN);
        end
    end

    always_comb begin
        status.fault    = (state_q == GS_SAFE);
        status.safe_off = (state_q == GS_SAFE);
        status.irq      = irq_q;
    end

    // R4: a sampled mismatch latches the fault
    p_miss_latches_r4: assert property (@(posedge clk) disable iff (rst)
        miss |=> status.fault);
    // R6: fault holds unless a clean clear arrives
    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (status.fault && !clr) |=> status.fault);
    // R5: interrupt is a single-cycle pulse
    p_irq_single_r5: assert property (@(posedge clk) disable iff (rst)
        status.irq |=> !status.irq);
    // R5: interrupt only coincides with the fault's rising edge
    p_irq_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
        status.irq |-> (status.fault && !$past(status.fault)));
endmodule

// File: rtl/ls_out_gate.sv
module ls_out_gate #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              block,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    always_comb begin
        out_valid = in_valid & ~block;
        out_data  = block ? '0 : in_data;
    end

    // R7: blocked cycles present the inactive value
    p_gate_zero_r7: assert property (@(posedge clk) disable iff (rst)
        block |-> (!out_valid && out_data == '0));
    // R1: unblocked cycles forward the primary result
    p_pass_r1: assert property (@(posedge clk) disable iff (rst)
        !block |-> (out_valid == in_valid && out_data == in_data));
endmodule

// File: rtl/lockstep_guard.sv
module lockstep_guard
    import lockstep_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pri_valid,
    input  logic [DATA_W-1:0] pri_data,
    input  logic              shd_valid,
    input  logic [DATA_W-1:0] shd_data,
    input  logic              clear_fault,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              fault,
    output logic              irq,
    output logic              safe_off
);
    logic          miss;
    logic          block;
    guard_status_t status;

    ls_compare #(.DATA_W(DATA_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .a_valid (pri_valid),
        .a_data  (pri_data),
        .b_valid (shd_valid),
        .b_data  (shd_data),
        .miss    (miss)
    );

    ls_fault_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .miss   (miss),
        .clr    (clear_fault),
        .status (status)
    );

    assign block = status.safe_off | miss;

    ls_out_gate #(.DATA_W(DATA_W)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .block     (block),
        .in_valid  (pri_valid),
        .in_data   (pri_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign fault    = status.fault;
    assign safe_off = status.safe_off;
    assign irq      = status.irq;

    // R8: reset clears the fault outputs
    p_reset_clean_r8: assert property (@(posedge clk)
        $past(rst) |-> (!fault && !safe_off && !irq));
endmodule

// File: tb/tb_lockstep_guard.sv
module tb_lockstep_guard;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         pri_valid, shd_valid, clear_fault;
    logic [W-1:0] pri_data, shd_data;
    logic         out_valid, fault, irq, safe_off;
    logic [W-1:0] out_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lockstep_guard #(.DATA_W(W)) dut (
        .clk(clk), .rst(rst),
        .pri_valid(pri_valid), .pri_data(pri_data),
        .shd_valid(shd_valid), .shd_data(shd_data),
        .clear_fault(clear_fault),
        .out_valid(out_valid), .out_data(out_data),
        .fault(fault), .irq(irq), .safe_off(safe_off)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive on falling edge
    task automatic drive(input logic pv, input logic [W-1:0] pd,
                         input logic sv, input logic [W-1:0] sd,
                         input logic clr);
        @(negedge clk);
        pri_valid = pv; pri_data = pd;
        shd_valid = sv; shd_data = sd;
        clear_fault = clr;
        #3;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pri_valid = 0; shd_valid = 0; pri_data = '0; shd_data = '0; clear_fault = 0;
        after_edge();
        after_edge();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic clean_clear();
        drive(1'b0, '0, 1'b0, '0, 1'b1);
        after_edge();
        chk("R6 clear drops fault", int'(fault), 0);
        chk("R6 clear drops safe_off", int'(safe_off), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        #3;
        chk("R8 reset fault", int'(fault), 0);
        chk("R8 reset safe_off", int'(safe_off), 0);
        chk("R8 reset irq", int'(irq), 0);

        // R1 R2 R4 R5 R7: sweep all valid word pairs
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                bit diff;
                diff = (a != b);
                drive(1'b1, W'(a), 1'b1, W'(b), 1'b0);
                if (diff) begin
                    chk("R7 mismatch cycle out_valid", int'(out_valid), 0);
                    chk("R7 mismatch cycle out_data", int'(out_data), 0);
                end else begin
                    chk("R1 pass out_valid", int'(out_valid), 1);
                    chk("R1 pass out_data", int'(out_data), a);
                end
                after_edge();
                chk("R4 fault after pair", int'(fault), int'(diff));
                chk("R4 safe_off after pair", int'(safe_off), int'(diff));
                chk("R5 irq after pair", int'(irq), int'(diff));
                if (diff) clean_clear();
            end
        end

        // R3: single strobe with equal data
        for (int s = 0; s < 2; s++) begin
            drive(s == 0, 4'h5, s == 1, 4'h5, 1'b0);
            chk("R3 single strobe blocks out_valid", int'(out_valid), 0);
            after_edge();
            chk("R3 single strobe fault", int'(fault), 1);
            chk("R5 single strobe irq", int'(irq), 1);
            clean_clear();
        end

        // R2: both idle, different words ignored
        for (int d = 1; d < 16; d++) begin
            drive(1'b0, 4'h0, 1'b0, W'(d), 1'b0);
            chk("R1 idle out_data", int'(out_data), 0);
            after_edge();
            chk("R2 idle no fault", int'(fault), 0);
            chk("R2 idle no irq", int'(irq), 0);
        end

        // R5: repeated mismatches give one pulse
        drive(1'b1, 4'h1, 1'b1, 4'h2, 1'b0);
        after_edge();
        chk("R5 first irq", int'(irq), 1);
        for (int k = 0; k < 3; k++) begin
            drive(1'b1, 4'h3, 1'b1, 4'h4, 1'b0);
            after_edge();
            chk("R5 no repeat irq", int'(irq), 0);
            chk("R6 fault held", int'(fault), 1);
        end

        // R7: matching traffic during safe-off is forced to zero
        drive(1'b1, 4'hA, 1'b1, 4'hA, 1'b0);
        chk("R7 safe_off out_valid", int'(out_valid), 0);
        chk("R7 safe_off out_data", int'(out_data), 0);
        after_edge();
        chk("R6 sticky over matches", int'(safe_off), 1);

        // R6: clear concurrent with mismatch keeps fault
        drive(1'b1, 4'h7, 1'b0, 4'h7, 1'b1);
        after_edge();
        chk("R6 mismatch beats clear", int'(fault), 1);
        chk("R5 no irq on clear race", int'(irq), 0);
        clean_clear();
        drive(1'b1, 4'h9, 1'b1, 4'h9, 1'b0);
        chk("R1 pass after clear", int'(out_data), 9);
        after_edge();

        // R8: reset while faulted
        drive(1'b1, 4'h1, 1'b1, 4'h0, 1'b0);
        after_edge();
        do_reset();
        #3;
        chk("R8 reset from fault", int'(fault), 0);
        chk("R8 reset from safe_off", int'(safe_off), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule